// File: doc/BRIEF.md
# Register-Direct Instruction Executor

This block executes a small subset of a 32-bit variable-length instruction set against eight 32-bit general registers. Instruction bytes arrive one at a time over a ready/valid byte stream. A first byte either acts on its own (the compact increment, decrement, push and pop ranges) or is followed by an operand-select byte. That second byte names a mode, a register or sub-operation field, and an operand register. A two-byte escape prefix selects a signed multiply.

Only register-direct operands are supported. Push and pop use a single-word memory port that takes one cycle. The register file is visible as a flat output vector. Each completed instruction gives a one-cycle retire pulse. Any encoding the block does not handle raises a sticky illegal flag that stops fetching until reset.

Top module: `rdx_exec`

## Requirements
- R1: Synchronous reset clears all eight registers (index 0..7), `illegal_o`, `retire_o` and `mem_req_o`, and leaves `in_ready` high.
- R2: The operand-select byte holds mode in bits 7:6, the register/sub-operation field in bits 5:3 and the operand register in bits 2:0. Only mode 3 executes; any other mode raises the illegal flag.
- R3: Opcodes 0x40..0x47 add one to, and 0x48..0x4F subtract one from, the register named by opcode bits 2:0. Both wrap modulo 2^32.
- R4: Opcodes 0x50..0x57 take the register named by bits 2:0, lower the stack register (index 4) by 4, and write the register's value as it stood before the instruction to memory at the lowered address.
- R5: Opcodes 0x58..0x5F read the word at the current stack-register address, raise the stack register by 4, and load the word into the named register. When the named register is the stack register, the loaded word wins.
- R6: Opcode 0x89 copies the field register into the operand register. Opcode 0x87 swaps the two registers, with both writes at one clock edge.
- R7: Opcode 0xFF with field 0 increments the operand register and with field 1 decrements it. Any other field raises the illegal flag.
- R8: Opcode 0xF7 with field 2 inverts the operand bitwise, and with field 3 negates it in two's complement (0x80000000 stays 0x80000000). With field 4 it forms the unsigned 64-bit product of register 0 and the operand, low half to register 0 and high half to register 2.
- R9: Opcode 0xF7 with field 7 divides the signed 64-bit value {register 2, register 0} by the signed operand, truncating toward zero. The quotient goes to register 0 and the remainder to register 2. A zero divisor or a quotient outside the signed 32-bit range raises the illegal flag.
- R10: The byte pair 0x0F 0xAF followed by an operand-select byte writes the low 32 bits of the signed product of the field register and the operand register into the field register. 0x0F followed by anything else raises the illegal flag.
- R11: Any other first byte, or any rejected sub-operation, raises `illegal_o`. The flag stays set until reset, `in_ready` stays low, and no register or memory state changes afterwards.
- R12: `retire_o` pulses for exactly one cycle per completed instruction. It rises in the same cycle the instruction's register results appear on `regs_o`, and never while `illegal_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Instruction byte |
| in_valid | input | 1 | Instruction byte is present |
| in_ready | output | 1 | Block accepts a byte this cycle |
| mem_req_o | output | 1 | Memory access request, one cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after the request |
| regs_o | output | 256 | Register file, register i in bits 32*i+31:32*i |
| retire_o | output | 1 | Instruction completed |
| illegal_o | output | 1 | Sticky illegal-instruction flag |

## Verification
Checked on every cycle are the control invariants: the illegal flag never clears without reset and holds `in_ready` low, and a push write or pop read always addresses the current stack register. A pop's data capture always directly follows its read request, and a retire pulse never coincides with the illegal flag. Arithmetic results need the bench's directed instruction sequences to show up: wrap-around, the negate corner, divide signs, and which register an opcode's low bits or field selects. The same holds for the exchange order, the loaded word winning on a pop into the stack register, and the stored value of a push of the stack register itself.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  // width of every register selector in the encoding; the register count follows from it
  localparam int FLD_W = 3;
  localparam int NREG  = 1 << FLD_W;

  localparam logic [1:0] MODE_REG   = 2'b11;
  localparam logic [7:0] OPC_ESC    = 8'h0F;
  localparam logic [7:0] OPC_IMUL2  = 8'hAF;
  localparam logic [7:0] OPC_MOV    = 8'h89;
  localparam logic [7:0] OPC_XCHG   = 8'h87;
  localparam logic [7:0] OPC_GRP_FF = 8'hFF;
  localparam logic [7:0] OPC_GRP_F7 = 8'hF7;

  // upper five opcode bits of the compact ranges that carry a register number
  localparam logic [4:0] RNG_INC  = 5'b01000;
  localparam logic [4:0] RNG_DEC  = 5'b01001;
  localparam logic [4:0] RNG_PUSH = 5'b01010;
  localparam logic [4:0] RNG_POP  = 5'b01011;

  typedef enum logic [2:0] {
    ST_OP, ST_ESC, ST_MODRM, ST_POPWAIT, ST_POPTAKE, ST_HALT
  } fsm_e;

  typedef enum logic [2:0] {
    AOP_NOT, AOP_NEG, AOP_MULU, AOP_IMUL, AOP_IDIV
  } alu_op_e;
endpackage

// File: rtl/rdx_regfile.sv
module rdx_regfile
  import rdx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_a,
  input  logic [FLD_W-1:0]     idx_a,
  input  logic [XLEN-1:0]      dat_a,
  input  logic                 we_b,
  input  logic [FLD_W-1:0]     idx_b,
  input  logic [XLEN-1:0]      dat_b,
  output logic [NREG*XLEN-1:0] flat_o
);
  // two write ports: port b wins when both hit one register
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (we_b && idx_b == FLD_W'(i)) begin
        q <= dat_b;
      end else if (we_a && idx_a == FLD_W'(i)) begin
        q <= dat_a;
      end
    end
    assign flat_o[i*XLEN +: XLEN] = q;
  end
endmodule

// File: rtl/rdx_alu.sv
module rdx_alu
  import rdx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  opnd,
  input  logic [XLEN-1:0]  rval,
  input  logic [XLEN-1:0]  acc_lo,
  input  logic [XLEN-1:0]  acc_hi,
  output logic [XLEN-1:0]  res_a,
  output logic [XLEN-1:0]  res_b,
  output logic             fault
);
  localparam int DW = 2 * XLEN;

  logic [DW-1:0]          prod_u;
  logic signed [XLEN-1:0] sm_a, sm_b, prod_s;
  logic signed [DW-1:0]   dvd, dvs, dvs_safe, quo;
  logic [XLEN-1:0]        rem_lo;
  logic                   div_zero, quo_fits;

  always_comb begin
    prod_u   = {{XLEN{1'b0}}, acc_lo} * {{XLEN{1'b0}}, opnd};
    sm_a     = rval;
    sm_b     = opnd;
    prod_s   = sm_a * sm_b;
    dvd      = {acc_hi, acc_lo};
    dvs      = {{XLEN{opnd[XLEN-1]}}, opnd};
    div_zero = (opnd == '0);
    dvs_safe = div_zero ? DW'(1) : dvs;
    quo      = dvd / dvs_safe;
    rem_lo   = XLEN'(dvd % dvs_safe);
    quo_fits = (quo[DW-1:XLEN-1] == '0) || (&quo[DW-1:XLEN-1]);

    res_a = '0;
    res_b = '0;
    fault = 1'b0;
    case (op)
      AOP_NOT:  res_a = ~opnd;
      AOP_NEG:  res_a = '0 - opnd;
      AOP_MULU: begin
        res_a = prod_u[XLEN-1:0];
        res_b = prod_u[DW-1:XLEN];
      end
      AOP_IMUL: res_a = prod_s;
      AOP_IDIV: begin
        res_a = quo[XLEN-1:0];
        res_b = rem_lo;
        fault = div_zero || !quo_fits;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rdx_exec.sv
module rdx_exec
  import rdx_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int SP_IDX     = 4,
  parameter int ACC_LO_IDX = 0,
  parameter int ACC_HI_IDX = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           in_byte,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [XLEN-1:0]      mem_addr_o,
  output logic [XLEN-1:0]      mem_wdata_o,
  input  logic [XLEN-1:0]      mem_rdata_i,
  output logic [NREG*XLEN-1:0] regs_o,
  output logic                 retire_o,
  output logic                 illegal_o
);
  localparam int              WB    = XLEN / 8;
  localparam logic [FLD_W-1:0] SP_F = FLD_W'(SP_IDX);
  localparam logic [FLD_W-1:0] LO_F = FLD_W'(ACC_LO_IDX);
  localparam logic [FLD_W-1:0] HI_F = FLD_W'(ACC_HI_IDX);

  fsm_e             st, st_n;
  logic [7:0]       op_q, op_n;
  logic             esc_q, esc_n;
  logic [FLD_W-1:0] popr_q, popr_n;
  logic [XLEN-1:0]  rv [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_view
    assign rv[i] = regs_o[i*XLEN +: XLEN];
  end

  assign in_ready = (st == ST_OP) || (st == ST_ESC) || (st == ST_MODRM);
  logic accept;
  assign accept = in_valid && in_ready;

  logic [1:0]       f_mode;
  logic [FLD_W-1:0] f_reg, f_rm;
  assign f_mode = in_byte[7:6];
  assign f_reg  = in_byte[5:3];
  assign f_rm   = in_byte[FLD_W-1:0];

  // arithmetic unit
  alu_op_e         a_op;
  logic [XLEN-1:0] a_res_a, a_res_b;
  logic            a_fault;

  always_comb begin
    if (esc_q) a_op = AOP_IMUL;
    else begin
      case (f_reg)
        3'd3:    a_op = AOP_NEG;
        3'd4:    a_op = AOP_MULU;
        3'd7:    a_op = AOP_IDIV;
        default: a_op = AOP_NOT;
      endcase
    end
  end

  rdx_alu #(.XLEN(XLEN)) alu_i (
    .op(a_op), .opnd(rv[f_rm]), .rval(rv[f_reg]),
    .acc_lo(rv[LO_F]), .acc_hi(rv[HI_F]),
    .res_a(a_res_a), .res_b(a_res_b), .fault(a_fault)
  );

  // execution decode
  logic             wa_en, wb_en, done, bad;
  logic [FLD_W-1:0] wa_idx, wb_idx;
  logic [XLEN-1:0]  wa_dat, wb_dat, sp_dn;
  logic             mreq_n, mwe_n;
  logic [XLEN-1:0]  maddr_n, mwd_n;

  assign sp_dn = rv[SP_F] - XLEN'(WB);

  always_comb begin
    st_n = st; op_n = op_q; esc_n = esc_q; popr_n = popr_q;
    wa_en = 1'b0; wa_idx = '0; wa_dat = '0;
    wb_en = 1'b0; wb_idx = '0; wb_dat = '0;
    mreq_n = 1'b0; mwe_n = 1'b0; maddr_n = '0; mwd_n = '0;
    done = 1'b0; bad = 1'b0;
    case (st)
      ST_OP: if (accept) begin
        op_n  = in_byte;
        esc_n = 1'b0;
        case (in_byte[7:3])
          RNG_INC: begin
            wa_en = 1'b1; wa_idx = f_rm; wa_dat = rv[f_rm] + 1'b1; done = 1'b1;
          end
          RNG_DEC: begin
            wa_en = 1'b1; wa_idx = f_rm; wa_dat = rv[f_rm] - 1'b1; done = 1'b1;
          end
          RNG_PUSH: begin
            wa_en = 1'b1; wa_idx = SP_F; wa_dat = sp_dn;
            mreq_n = 1'b1; mwe_n = 1'b1; maddr_n = sp_dn; mwd_n = rv[f_rm];
            done = 1'b1;
          end
          RNG_POP: begin
            mreq_n = 1'b1; maddr_n = rv[SP_F]; popr_n = f_rm; st_n = ST_POPWAIT;
          end
          default: begin
            if (in_byte == OPC_ESC) st_n = ST_ESC;
            else if (in_byte == OPC_MOV || in_byte == OPC_XCHG ||
                     in_byte == OPC_GRP_FF || in_byte == OPC_GRP_F7) st_n = ST_MODRM;
            else bad = 1'b1;
          end
        endcase
      end
      ST_ESC: if (accept) begin
        if (in_byte == OPC_IMUL2) begin
          esc_n = 1'b1; st_n = ST_MODRM;
        end else bad = 1'b1;
      end
      ST_MODRM: if (accept) begin
        if (f_mode != MODE_REG) bad = 1'b1;
        else if (esc_q) begin
          wa_en = 1'b1; wa_idx = f_reg; wa_dat = a_res_a;
        end else begin
          case (op_q)
            OPC_MOV: begin
              wa_en = 1'b1; wa_idx = f_rm; wa_dat = rv[f_reg];
            end
            OPC_XCHG: begin
              wa_en = 1'b1; wa_idx = f_rm;  wa_dat = rv[f_reg];
              wb_en = 1'b1; wb_idx = f_reg; wb_dat = rv[f_rm];
            end
            OPC_GRP_FF: begin
              wa_idx = f_rm;
              if (f_reg == 3'd0)      begin wa_en = 1'b1; wa_dat = rv[f_rm] + 1'b1; end
              else if (f_reg == 3'd1) begin wa_en = 1'b1; wa_dat = rv[f_rm] - 1'b1; end
              else bad = 1'b1;
            end
            OPC_GRP_F7: begin
              case (f_reg)
                3'd2, 3'd3: begin
                  wa_en = 1'b1; wa_idx = f_rm; wa_dat = a_res_a;
                end
                3'd4, 3'd7: begin
                  wa_en = 1'b1; wa_idx = LO_F; wa_dat = a_res_a;
                  wb_en = 1'b1; wb_idx = HI_F; wb_dat = a_res_b;
                  bad = a_fault;
                end
                default: bad = 1'b1;
              endcase
            end
            default: bad = 1'b1;
          endcase
        end
        if (!bad) begin
          done = 1'b1; st_n = ST_OP;
        end
      end
      ST_POPWAIT: st_n = ST_POPTAKE;
      ST_POPTAKE: begin
        wa_en = 1'b1; wa_idx = SP_F;   wa_dat = rv[SP_F] + XLEN'(WB);
        wb_en = 1'b1; wb_idx = popr_q; wb_dat = mem_rdata_i;
        done = 1'b1; st_n = ST_OP;
      end
      default: st_n = ST_HALT;
    endcase
    if (bad) begin
      st_n = ST_HALT; wa_en = 1'b0; wb_en = 1'b0; mreq_n = 1'b0; done = 1'b0;
    end
  end

  rdx_regfile #(.XLEN(XLEN)) rf_i (
    .clk(clk), .rst(rst),
    .we_a(wa_en), .idx_a(wa_idx), .dat_a(wa_dat),
    .we_b(wb_en), .idx_b(wb_idx), .dat_b(wb_dat),
    .flat_o(regs_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_OP; op_q <= '0; esc_q <= 1'b0; popr_q <= '0;
      mem_req_o <= 1'b0; mem_we_o <= 1'b0; mem_addr_o <= '0; mem_wdata_o <= '0;
      retire_o <= 1'b0; illegal_o <= 1'b0;
    end else begin
      st <= st_n; op_q <= op_n; esc_q <= esc_n; popr_q <= popr_n;
      mem_req_o <= mreq_n; mem_we_o <= mwe_n; mem_addr_o <= maddr_n; mem_wdata_o <= mwd_n;
      retire_o <= done;
      illegal_o <= illegal_o | bad;
    end
  end

  // R11
  sticky_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |=> illegal_o);
  // R11
  halt_noready_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !in_ready);
  // R4
  push_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> (mem_addr_o == rv[SP_F]));
  // R5
  pop_read_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_POPWAIT) |-> (mem_req_o && !mem_we_o && mem_addr_o == rv[SP_F]));
  // R5
  pop_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_POPTAKE) |-> $past(st == ST_POPWAIT));
  // R12
  retire_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    !(retire_o && illegal_o));
endmodule

// File: tb/rdx_exec_tb.sv
`timescale 1ns/1ps
module rdx_exec_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   in_byte = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         mem_req_o, mem_we_o;
  logic [31:0]  mem_addr_o, mem_wdata_o;
  logic [31:0]  mem_rdata_i = '0;
  logic [255:0] regs_o;
  logic         retire_o, illegal_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  rdx_exec dut_i (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .regs_o(regs_o), .retire_o(retire_o), .illegal_o(illegal_o)
  );

  // bench memory, one-cycle read
  logic [31:0] ram [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return ram.exists(a) ? ram[a] : 32'h0;
  endfunction
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) ram[mem_addr_o] = mem_wdata_o;
      else mem_rdata_i <= rd(mem_addr_o);
    end
  end

  // behavioural model
  logic [31:0] mr [8];
  logic [31:0] mm [logic [31:0]];
  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mm.exists(a) ? mm[a] : 32'h0;
  endfunction

  logic [255:0] exp_q [$];
  string        tag_q [$];
  logic [255:0] e_cur;
  string        t_cur;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] snap();
    logic [255:0] s;
    for (int i = 0; i < 8; i++) s[i*32 +: 32] = mr[i];
    return s;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && retire_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected retire: actual=1 expected=0");
      end else begin
        e_cur = exp_q.pop_front();
        t_cur = tag_q.pop_front();
        if (regs_o !== e_cur) begin
          n_fail++;
          $display("FAIL %s: actual=%h expected=%h", t_cur, regs_o, e_cur);
        end
      end
    end
  end

  task automatic model(input logic [7:0] op, input logic [7:0] b, input bit esc);
    logic [2:0] r, m;
    logic [31:0] t;
    logic [63:0] p;
    longint dvd, dvs, q, rm;
    r = b[5:3]; m = b[2:0];
    if (esc) begin
      mr[r] = int'(mr[r]) * int'(mr[m]);
      return;
    end
    case (op[7:3])
      5'b01000: begin mr[op[2:0]] += 1; return; end
      5'b01001: begin mr[op[2:0]] -= 1; return; end
      5'b01010: begin t = mr[op[2:0]]; mr[4] -= 4; mm[mr[4]] = t; return; end
      5'b01011: begin t = mrd(mr[4]); mr[4] += 4; mr[op[2:0]] = t; return; end
      default: ;
    endcase
    case (op)
      8'h89: mr[m] = mr[r];
      8'h87: begin t = mr[m]; mr[m] = mr[r]; mr[r] = t; end
      8'hFF: if (r == 0) mr[m] += 1; else mr[m] -= 1;
      8'hF7: case (r)
        3'd2: mr[m] = ~mr[m];
        3'd3: mr[m] = -mr[m];
        3'd4: begin p = 64'(mr[0]) * 64'(mr[m]); mr[0] = p[31:0]; mr[2] = p[63:32]; end
        default: begin
          dvd = longint'({mr[2], mr[0]});
          dvs = longint'(int'(mr[m]));
          q = dvd / dvs; rm = dvd % dvs;
          mr[0] = q[31:0]; mr[2] = rm[31:0];
        end
      endcase
      default: ;
    endcase
  endtask

  task automatic send(input logic [7:0] b);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ins1(input string tag, input logic [7:0] op);
    model(op, 8'h00, 1'b0); exp_q.push_back(snap()); tag_q.push_back(tag);
    send(op);
  endtask
  task automatic ins2(input string tag, input logic [7:0] op, input logic [7:0] b);
    model(op, b, 1'b0); exp_q.push_back(snap()); tag_q.push_back(tag);
    send(op); send(b);
  endtask
  task automatic ins_mul(input string tag, input logic [7:0] b);
    model(8'h0F, b, 1'b1); exp_q.push_back(snap()); tag_q.push_back(tag);
    send(8'h0F); send(8'hAF); send(b);
  endtask
  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask
  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) mr[i] = '0;
    exp_q.delete(); tag_q.delete();
  endtask
  task automatic preload(input logic [31:0] a, input logic [31:0] v);
    ram[a] = v; mm[a] = v;
  endtask

  task automatic illegal_case(input string tag, input logic [7:0] b0, input logic [7:0] b1, input int nb);
    do_reset();
    send(b0);
    if (nb > 1) send(b1);
    repeat (3) @(negedge clk);
    chk({tag, " flag"}, 32'(illegal_o), 32'h1);
    chk({tag, " R11 ready"}, 32'(in_ready), 32'h0);
    chk({tag, " R11 regs"}, 32'(|regs_o), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 regs", 32'(|regs_o), 32'h0);
    chk("R1 illegal", 32'(illegal_o), 32'h0);
    chk("R1 ready", 32'(in_ready), 32'h1);
    chk("R1 retire", 32'(retire_o), 32'h0);
    chk("R1 mem_req", 32'(mem_req_o), 32'h0);

    // phase 1: load registers by popping
    preload(32'h00, 32'h0000_0010); preload(32'h04, 32'h0000_0003);
    preload(32'h08, 32'h0000_0000); preload(32'h0C, 32'h0000_0001);
    preload(32'h10, 32'h7FFF_FFFF); preload(32'h14, 32'h8000_0000);
    preload(32'h18, 32'hFFFF_FFFF); preload(32'h1C, 32'h0000_0400);
    ins1("R5 pop r0", 8'h58); ins1("R5 pop r1", 8'h59);
    ins1("R5 pop r2", 8'h5A); ins1("R5 pop r3", 8'h5B);
    ins1("R5 pop r5", 8'h5D); ins1("R5 pop r6", 8'h5E);
    ins1("R5 pop r7", 8'h5F); ins1("R5 pop into stack reg", 8'h5C);
    ins1("R3 inc r0", 8'h40); ins1("R3 dec r7", 8'h4F);
    ins1("R3 inc r7", 8'h47); ins1("R3 inc r7 wrap", 8'h47);
    ins1("R3 dec r2 wrap", 8'h4A);
    ins1("R4 push r3", 8'h53); ins1("R4 push stack reg", 8'h54);
    ins2("R2 R6 copy r3 to r0", 8'h89, 8'hD8);
    ins2("R6 swap r1 r6", 8'h87, 8'hCE);
    ins2("R7 inc r3", 8'hFF, 8'hC3); ins2("R7 dec r3", 8'hFF, 8'hCB);
    ins2("R8 not r5", 8'hF7, 8'hD5); ins2("R8 neg r6", 8'hF7, 8'hDE);
    ins2("R8 mulu r0 by r1", 8'hF7, 8'hE1);
    ins2("R8 neg min value", 8'hF7, 8'hDD);
    ins1("R5 pop after push", 8'h5E);
    drain();
    chk("R4 push data", rd(32'h3FC), 32'h0000_0001);
    chk("R4 push of stack reg stores old value", rd(32'h3F8), 32'h0000_03FC);
    chk("R5 stack reg after pops", regs_o[4*32 +: 32], 32'h0000_03FC);
    chk("R8 neg min stays", regs_o[5*32 +: 32], 32'h8000_0000);

    // phase 2: divide and signed multiply
    do_reset();
    preload(32'h00, 32'hFFFF_FFF9); preload(32'h04, 32'h0000_0003);
    preload(32'h08, 32'hFFFF_FFFF); preload(32'h0C, 32'hFFFF_FFFD);
    ins1("R5 pop r0", 8'h58); ins1("R5 pop r1", 8'h59);
    ins1("R5 pop r2", 8'h5A); ins1("R5 pop r3", 8'h5B);
    ins2("R9 signed divide", 8'hF7, 8'hF9);
    ins_mul("R10 signed multiply", 8'hD9);
    ins2("R9 divide small", 8'hF7, 8'hF9);
    ins2("R8 mulu zero", 8'hF7, 8'hE1);
    drain();
    chk("R10 product", regs_o[3*32 +: 32], 32'hFFFF_FFF7);

    // illegal encodings
    illegal_case("R11 unknown opcode", 8'h01, 8'h00, 1);
    // halted: offered bytes are ignored
    in_valid = 1'b1; in_byte = 8'h40;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    chk("R11 ignored byte", regs_o[31:0], 32'h0);
    illegal_case("R2 memory mode", 8'h89, 8'h18, 2);
    illegal_case("R7 bad sub-op", 8'hFF, 8'hD0, 2);
    illegal_case("R8 bad sub-op", 8'hF7, 8'hC0, 2);
    illegal_case("R9 zero divisor", 8'hF7, 8'hF9, 2);
    illegal_case("R10 bad escape", 8'h0F, 8'h00, 2);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule